// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point operands in the common single-precision format. The format has 1 sign bit, an 8-bit biased exponent with bias 127 and a 23-bit fraction. A one-cycle `start_i` pulse captures both operands, the add/subtract select and the rounding mode. The block then steps through a fixed sequence. It compares the exponents and aligns the smaller operand, adds or subtracts the significands, normalizes, then rounds and renormalizes. One cycle after the last step it raises `done_o` with the packed result and two exception flags.

Three extra bits sit below the significand all the way to the rounding stage: a guard bit, a round bit and a sticky bit. The sticky bit is the OR of everything shifted out further down. These bits let any of four rounding modes pick the correctly rounded result. Denormal inputs and outputs, infinities and NaNs are handled in full. Only one operation is in flight at a time.

Top module: `fp_addsub`

## Requirements
- R1: When both operands are finite, the operand with the smaller exponent is shifted right to match the larger one, and the result is the correctly rounded sum (for example 1.0 + 2.0 gives 0x40400000).
- R2: `sub_i` = 1 inverts the sign of operand B. When the resulting signs differ, the magnitudes are subtracted and the result takes the sign of the operand with the larger magnitude.
- R3: A carry out of the significand sum shifts the result right by one and raises the exponent by one. Cancellation shifts the result left and lowers the exponent, but never below the denormal exponent.
- R4: `rmode_i` selects the rounding mode: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward zero, 2'b10 rounds toward +infinity and 2'b11 rounds toward -infinity. The decision uses the guard bit, the round bit and the sticky bit.
- R5: When rounding carries out of the significand, the result is renormalized: the fraction becomes zero and the exponent rises by one.
- R6: A rounded exponent of 255 or more raises `overflow_o`. The result is then infinity under nearest rounding, and under directed rounding toward the result's own sign. Otherwise it is the largest finite value with the result's sign (0x7F7FFFFF in magnitude).
- R7: An exponent field of 0 means a denormal: there is no hidden 1 and the exponent is -126. A result too small to be normal is encoded as a denormal. `underflow_o` is set exactly when the result has exponent field 0 and a nonzero fraction.
- R8: A NaN on either operand, or the sum of two infinities with opposite effective signs, gives the quiet NaN 0x7FC00000 with both flags clear.
- R9: An infinite operand, when R8 does not apply, gives that infinity with its effective sign, with both flags clear.
- R10: An exact zero from operands with opposite effective signs is +0, or -0 under rounding toward -infinity. Two zeros with the same effective sign keep that sign.
- R11: `done_o` is a one-cycle pulse four rising edges after the edge that accepts `start_i`. `result_o` and the flags change only in that cycle and hold until the next pulse.
- R12: `start_i` is ignored while an operation is in flight, including the cycles before `done_o`.
- R13: After reset `done_o`, `result_o`, `overflow_o` and `underflow_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation with the values on the operand and control inputs |
| sub_i | input | 1 | 1 = A minus B, 0 = A plus B |
| rmode_i | input | 2 | Rounding mode, encoded as in R4 |
| op_a_i | input | 32 | Operand A, packed single precision |
| op_b_i | input | 32 | Operand B, packed single precision |
| result_o | output | 32 | Packed result, valid from the `done_o` cycle |
| overflow_o | output | 1 | Result exponent overflowed (R6) |
| underflow_o | output | 1 | Result is a nonzero denormal (R7) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The rounding increment and the overflow decision can fall in the same cycle. A significand of all ones at the largest finite exponent can be pushed over the top by the round-up alone. The bench provokes this by adding 0x7F7FFFFF to 2^103 (0x73000000). That addend lands exactly on the guard bit and leaves an odd last bit. Under nearest-even rounding the result must be +infinity with `overflow_o` set. Under round-toward-zero the same operands must give 0x7F7FFFFF with no flag. The bench also drives a carry at a small exponent (0x3FFFFFFF + 2^-24) to keep the renormalization step apart from the overflow check.

// File: rtl/fp_addsub_pkg.sv
package fp_addsub_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALIGN,
      ST_ADD,
      ST_NORM,
      ST_ROUND
   } fsm_e;

   localparam logic [1:0] RM_NEAREST = 2'b00;
   localparam logic [1:0] RM_ZERO    = 2'b01;
   localparam logic [1:0] RM_UP      = 2'b10;
   localparam logic [1:0] RM_DOWN    = 2'b11;
endpackage

// File: rtl/fp_addsub_align.sv
// Right shift of the smaller significand; every bit pushed out is folded
// into bit 0 as the sticky bit.
module fp_addsub_align #(
   parameter int XW = 27,
   parameter int EW = 10
) (
   input  logic [XW-1:0] val_i,
   input  logic [EW-1:0] dist_i,
   output logic [XW-1:0] val_o
);
   localparam int DW = $clog2(XW + 1);

   logic [DW-1:0] dist_c;
   logic [XW-1:0] lost;

   always_comb begin
      dist_c = (dist_i > EW'(XW)) ? DW'(XW) : DW'(dist_i);
      lost   = val_i & ~({XW{1'b1}} << dist_c);
      val_o  = (val_i >> dist_c) | {{(XW-1){1'b0}}, |lost};
   end
endmodule

// File: rtl/fp_addsub_norm.sv
// Normalizes the raw sum: a carry moves it right one place, cancellation
// moves it left, limited so the exponent never drops below 1.
module fp_addsub_norm #(
   parameter int XW = 27,
   parameter int EW = 10
) (
   input  logic [XW:0]   sum_i,
   input  logic [EW-1:0] exp_i,
   output logic [XW-1:0] sig_o,
   output logic [EW-1:0] exp_o,
   output logic          zero_o
);
   localparam int LZW = $clog2(XW + 1);

   logic [LZW-1:0] lz;
   logic [EW-1:0]  room;
   logic [EW-1:0]  sh;

   always_comb begin
      lz = LZW'(XW);
      for (int i = 0; i < XW; i++) begin
         if (sum_i[i]) lz = LZW'(XW - 1 - i);
      end
   end

   always_comb begin
      room   = exp_i - EW'(1);
      sh     = (EW'(lz) < room) ? EW'(lz) : room;
      zero_o = ~|sum_i;
      if (sum_i[XW]) begin
         sig_o = {sum_i[XW:2], |sum_i[1:0]};
         exp_o = exp_i + EW'(1);
      end else begin
         sig_o = sum_i[XW-1:0] << sh;
         exp_o = exp_i - sh;
      end
   end
endmodule

// File: rtl/fp_addsub_round.sv
// Rounding, renormalization after a round carry, and the overflow and
// denormal encoding of the final word.
module fp_addsub_round
   import fp_addsub_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [MAN_W+3:0]         sig_i,
   input  logic [EXP_W+1:0]         exp_i,
   input  logic                     sign_i,
   input  logic [1:0]               rm_i,
   output logic [EXP_W+MAN_W:0]     res_o,
   output logic                     ovf_o,
   output logic                     unf_o
);
   localparam int SW = MAN_W + 1;
   localparam int EW = EXP_W + 2;
   localparam logic [EW-1:0] EMAX = EW'((1 << EXP_W) - 1);

   logic          lsb, grd, rest, inc, to_inf;
   logic [SW:0]   rsum;
   logic [EW-1:0] exp_r;
   logic [MAN_W-1:0] frac;

   always_comb begin
      lsb  = sig_i[3];
      grd  = sig_i[2];
      rest = |sig_i[1:0];
      unique case (rm_i)
         RM_NEAREST: inc = grd & (rest | lsb);
         RM_ZERO:    inc = 1'b0;
         RM_UP:      inc = ~sign_i & (grd | rest);
         default:    inc = sign_i & (grd | rest);
      endcase
      rsum = {1'b0, sig_i[SW+2:3]} + (SW+1)'(inc);
      if (rsum[SW]) begin
         frac  = rsum[SW-1:1];
         exp_r = exp_i + EW'(1);
      end else begin
         frac  = rsum[MAN_W-1:0];
         exp_r = rsum[MAN_W] ? exp_i : '0;
      end
      ovf_o  = (exp_r >= EMAX);
      to_inf = (rm_i == RM_NEAREST) | ((rm_i == RM_UP) & ~sign_i) |
               ((rm_i == RM_DOWN) & sign_i);
      if (ovf_o)
         res_o = to_inf ? {sign_i, EMAX[EXP_W-1:0], {MAN_W{1'b0}}}
                        : {sign_i, EMAX[EXP_W-1:1], 1'b0, {MAN_W{1'b1}}};
      else
         res_o = {sign_i, exp_r[EXP_W-1:0], frac};
      unf_o = ~ovf_o & (exp_r == '0) & (|frac);
   end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
   import fp_addsub_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic                   sub_i,
   input  logic [1:0]             rmode_i,
   input  logic [EXP_W+MAN_W:0]   op_a_i,
   input  logic [EXP_W+MAN_W:0]   op_b_i,
   output logic [EXP_W+MAN_W:0]   result_o,
   output logic                   overflow_o,
   output logic                   underflow_o,
   output logic                   done_o
);
   localparam int W  = EXP_W + MAN_W + 1;
   localparam int SW = MAN_W + 1;
   localparam int XW = SW + 3;
   localparam int EW = EXP_W + 2;
   localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   // operand fields and classes
   logic             a_s, b_s;
   logic [EXP_W-1:0] a_e, b_e;
   logic [MAN_W-1:0] a_f, b_f;
   logic             a_nan, b_nan, a_inf, b_inf;
   logic [W-1:0]     spec_val;

   assign a_s   = op_a_i[W-1];
   assign a_e   = op_a_i[W-2:MAN_W];
   assign a_f   = op_a_i[MAN_W-1:0];
   assign b_s   = op_b_i[W-1] ^ sub_i;
   assign b_e   = op_b_i[W-2:MAN_W];
   assign b_f   = op_b_i[MAN_W-1:0];
   assign a_nan = (&a_e) & (|a_f);
   assign b_nan = (&b_e) & (|b_f);
   assign a_inf = (&a_e) & ~(|a_f);
   assign b_inf = (&b_e) & ~(|b_f);

   always_comb begin
      if (a_nan | b_nan | (a_inf & b_inf & (a_s ^ b_s))) spec_val = QNAN;
      else if (a_inf) spec_val = {a_s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      else            spec_val = {b_s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
   end

   // state held for the single operation in flight
   fsm_e          state;
   logic          c_sa, c_sb, c_spec;
   logic [EW-1:0] c_ea, c_eb;
   logic [SW-1:0] c_ma, c_mb;
   logic [W-1:0]  c_spec_val;
   logic [1:0]    c_rm;
   logic [XW-1:0] x_big, x_small;
   logic [EW-1:0] x_e;
   logic          x_sign, x_sub, x_zsign;
   logic [XW:0]   sum_q;
   logic [XW-1:0] r_sig;
   logic [EW-1:0] r_e;
   logic          r_zero;

   // exponent compare and alignment
   logic          a_big;
   logic [EW-1:0] big_e, small_e;
   logic [SW-1:0] big_m, small_m;
   logic [XW-1:0] small_al;

   always_comb begin
      a_big   = {c_ea, c_ma} >= {c_eb, c_mb};
      big_e   = a_big ? c_ea : c_eb;
      small_e = a_big ? c_eb : c_ea;
      big_m   = a_big ? c_ma : c_mb;
      small_m = a_big ? c_mb : c_ma;
   end

   fp_addsub_align #(.XW(XW), .EW(EW)) u_align (
      .val_i  ({small_m, 3'b000}),
      .dist_i (big_e - small_e),
      .val_o  (small_al)
   );

   // normalization
   logic [XW-1:0] n_sig;
   logic [EW-1:0] n_e;
   logic          n_zero;

   fp_addsub_norm #(.XW(XW), .EW(EW)) u_norm (
      .sum_i  (sum_q),
      .exp_i  (x_e),
      .sig_o  (n_sig),
      .exp_o  (n_e),
      .zero_o (n_zero)
   );

   // rounding
   logic [W-1:0] rnd_res;
   logic         rnd_ovf, rnd_unf;

   fp_addsub_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
      .sig_i  (r_sig),
      .exp_i  (r_e),
      .sign_i (x_sign),
      .rm_i   (c_rm),
      .res_o  (rnd_res),
      .ovf_o  (rnd_ovf),
      .unf_o  (rnd_unf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         {c_sa, c_sb, c_spec, c_ea, c_eb, c_ma, c_mb, c_spec_val, c_rm} <= '0;
         {x_big, x_small, x_e, x_sign, x_sub, x_zsign} <= '0;
         {sum_q, r_sig, r_e, r_zero} <= '0;
         result_o    <= '0;
         overflow_o  <= 1'b0;
         underflow_o <= 1'b0;
         done_o      <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state)
            ST_IDLE: if (start_i) begin
               c_sa       <= a_s;
               c_sb       <= b_s;
               c_ea       <= (a_e == '0) ? EW'(1) : EW'(a_e);
               c_eb       <= (b_e == '0) ? EW'(1) : EW'(b_e);
               c_ma       <= {|a_e, a_f};
               c_mb       <= {|b_e, b_f};
               c_spec     <= a_nan | b_nan | a_inf | b_inf;
               c_spec_val <= spec_val;
               c_rm       <= rmode_i;
               state      <= ST_ALIGN;
            end
            ST_ALIGN: begin
               x_big   <= {big_m, 3'b000};
               x_small <= small_al;
               x_e     <= big_e;
               x_sign  <= a_big ? c_sa : c_sb;
               x_sub   <= c_sa ^ c_sb;
               x_zsign <= (c_sa ^ c_sb) ? (c_rm == RM_DOWN) : c_sa;
               state   <= ST_ADD;
            end
            ST_ADD: begin
               sum_q <= x_sub ? ({1'b0, x_big} - {1'b0, x_small})
                              : ({1'b0, x_big} + {1'b0, x_small});
               state <= ST_NORM;
            end
            ST_NORM: begin
               r_sig  <= n_sig;
               r_e    <= n_e;
               r_zero <= n_zero;
               state  <= ST_ROUND;
            end
            ST_ROUND: begin
               if (c_spec) begin
                  result_o    <= c_spec_val;
                  overflow_o  <= 1'b0;
                  underflow_o <= 1'b0;
               end else if (r_zero) begin
                  result_o    <= {x_zsign, {(W-1){1'b0}}};
                  overflow_o  <= 1'b0;
                  underflow_o <= 1'b0;
               end else begin
                  result_o    <= rnd_res;
                  overflow_o  <= rnd_ovf;
                  underflow_o <= rnd_unf;
               end
               done_o <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fp_addsub_chk.sv
module fp_addsub_chk #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic [EXP_W+MAN_W:0] op_a_i,
   input logic [EXP_W+MAN_W:0] op_b_i,
   input logic [EXP_W+MAN_W:0] result_o,
   input logic                 overflow_o,
   input logic                 underflow_o,
   input logic                 done_o
);
   localparam int W = EXP_W + MAN_W + 1;
   localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   initial begin
      a_param_widths: assert (EXP_W >= 3 && MAN_W >= 4)
         else $error("fp_addsub: exponent or fraction width too small");
   end

   logic       busy_m, nan_m, accept;
   logic [2:0] cnt_m;
   logic       a_nan_in, b_nan_in;

   assign a_nan_in = (&op_a_i[W-2:MAN_W]) & (|op_a_i[MAN_W-1:0]);
   assign b_nan_in = (&op_b_i[W-2:MAN_W]) & (|op_b_i[MAN_W-1:0]);
   assign accept   = start_i & (~busy_m | done_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_m <= 1'b0;
         nan_m  <= 1'b0;
         cnt_m  <= '0;
      end else if (accept) begin
         busy_m <= 1'b1;
         nan_m  <= a_nan_in | b_nan_in;
         cnt_m  <= '0;
      end else if (done_o) begin
         busy_m <= 1'b0;
      end else if (busy_m && cnt_m != 3'd7) begin
         cnt_m <= cnt_m + 3'd1;
      end
   end

   // R11: completion comes exactly four edges after acceptance
   a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_m && cnt_m == 3'd4));
   a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_o) |-> done_o);
   // R6: an overflowed result is infinity or the largest finite magnitude
   a_r6_ovf_value: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && overflow_o) |->
         ((&result_o[W-2:MAN_W]) && result_o[MAN_W-1:0] == '0) ||
         (result_o[W-2:MAN_W] == {{(EXP_W-1){1'b1}}, 1'b0} && (&result_o[MAN_W-1:0])));
   // R7: underflow only on a nonzero denormal encoding
   a_r7_unf_denorm: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && underflow_o) |->
         (result_o[W-2:MAN_W] == '0 && result_o[MAN_W-1:0] != '0));
   // R8: a NaN operand always produces the quiet NaN without flags
   a_r8_nan_out: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && nan_m) |-> (result_o == QNAN && !overflow_o && !underflow_o));
endmodule

bind fp_addsub fp_addsub_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fp_addsub_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .op_a_i      (op_a_i),
   .op_b_i      (op_b_i),
   .result_o    (result_o),
   .overflow_o  (overflow_o),
   .underflow_o (underflow_o),
   .done_o      (done_o)
);

// File: tb/tb_fp_addsub.sv
`timescale 1ns/1ps
module tb_fp_addsub;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        sub_i = 1'b0;
   logic [1:0]  rmode_i = 2'b00;
   logic [31:0] op_a_i = '0, op_b_i = '0;
   logic [31:0] result_o;
   logic        overflow_o, underflow_o, done_o;

   int n_cmp = 0;
   int n_bad = 0;
   int lat;
   logic [31:0] res;
   logic ov, un;

   localparam logic [1:0] NE = 2'b00, TZ = 2'b01, UP = 2'b10, DN = 2'b11;

   always #2.5 clk = ~clk;

   fp_addsub dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i),
      .rmode_i(rmode_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
      .result_o(result_o), .overflow_o(overflow_o),
      .underflow_o(underflow_o), .done_o(done_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                         input logic s, input logic [1:0] m);
      @(negedge clk);
      op_a_i = a; op_b_i = b; sub_i = s; rmode_i = m; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      for (int i = 1; i <= 10; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (done_o) begin lat = i; break; end
      end
      res = result_o; ov = overflow_o; un = underflow_o;
   endtask

   task automatic op_chk(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic s, input logic [1:0] m, input logic [31:0] exp,
                         input logic eo, input logic eu);
      run_op(a, b, s, m);
      chk(tag, {res[31:0]}, exp);
      chk({tag, " flags"}, {30'd0, ov, un}, {30'd0, eo, eu});
   endtask

   task automatic t_reset;
      chk("R13 reset result", result_o, 32'h0);
      chk("R13 reset done/flags", {29'd0, done_o, overflow_o, underflow_o}, 32'h0);
   endtask

   task automatic t_add_sub;
      op_chk("R1 1+2", 32'h3F800000, 32'h40000000, 1'b0, NE, 32'h40400000, 1'b0, 1'b0);
      op_chk("R2 1-0.75 via sub", 32'h3F800000, 32'h3F400000, 1'b1, NE, 32'h3E800000, 1'b0, 1'b0);
      op_chk("R2 1+(-0.75) via signs", 32'h3F800000, 32'hBF400000, 1'b0, NE, 32'h3E800000, 1'b0, 1'b0);
      op_chk("R2 0.75-1 sign of larger", 32'h3F400000, 32'h3F800000, 1'b1, NE, 32'hBE800000, 1'b0, 1'b0);
      op_chk("R3 1.5+1.5 carry", 32'h3FC00000, 32'h3FC00000, 1'b0, NE, 32'h40400000, 1'b0, 1'b0);
      op_chk("R3 3-1.5 shift left", 32'h40400000, 32'h3FC00000, 1'b1, NE, 32'h3FC00000, 1'b0, 1'b0);
   endtask

   task automatic t_round;
      op_chk("R4 tie nearest even", 32'h3F800000, 32'h33800000, 1'b0, NE, 32'h3F800000, 1'b0, 1'b0);
      op_chk("R4 tie odd goes up", 32'h3F800001, 32'h33800000, 1'b0, NE, 32'h3F800002, 1'b0, 1'b0);
      op_chk("R4 sticky above half", 32'h3F800000, 32'h33800001, 1'b0, NE, 32'h3F800001, 1'b0, 1'b0);
      op_chk("R4 toward zero", 32'h3F800000, 32'h33800000, 1'b0, TZ, 32'h3F800000, 1'b0, 1'b0);
      op_chk("R4 up positive", 32'h3F800000, 32'h33800000, 1'b0, UP, 32'h3F800001, 1'b0, 1'b0);
      op_chk("R4 down positive", 32'h3F800000, 32'h33800000, 1'b0, DN, 32'h3F800000, 1'b0, 1'b0);
      op_chk("R4 up negative", 32'hBF800000, 32'hB3800000, 1'b0, UP, 32'hBF800000, 1'b0, 1'b0);
      op_chk("R4 down negative", 32'hBF800000, 32'hB3800000, 1'b0, DN, 32'hBF800001, 1'b0, 1'b0);
      op_chk("R4 far sticky up", 32'h3F800000, 32'h00000001, 1'b0, UP, 32'h3F800001, 1'b0, 1'b0);
      op_chk("R4 far sticky nearest", 32'h3F800000, 32'h00000001, 1'b0, NE, 32'h3F800000, 1'b0, 1'b0);
      op_chk("R5 round carry renorm", 32'h3FFFFFFF, 32'h33800000, 1'b0, NE, 32'h40000000, 1'b0, 1'b0);
   endtask

   task automatic t_overflow;
      op_chk("R6 max+max nearest", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, NE, 32'h7F800000, 1'b1, 1'b0);
      op_chk("R6 max+max zero", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, TZ, 32'h7F7FFFFF, 1'b1, 1'b0);
      op_chk("R6 max+max down", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, DN, 32'h7F7FFFFF, 1'b1, 1'b0);
      op_chk("R6 neg up", 32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, UP, 32'hFF7FFFFF, 1'b1, 1'b0);
      op_chk("R6 neg down", 32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, DN, 32'hFF800000, 1'b1, 1'b0);
      op_chk("R6 round pushes over", 32'h7F7FFFFF, 32'h73000000, 1'b0, NE, 32'h7F800000, 1'b1, 1'b0);
      op_chk("R6 same, toward zero", 32'h7F7FFFFF, 32'h73000000, 1'b0, TZ, 32'h7F7FFFFF, 1'b0, 1'b0);
   endtask

   task automatic t_denorm;
      op_chk("R7 tiny+tiny", 32'h00000001, 32'h00000001, 1'b0, NE, 32'h00000002, 1'b0, 1'b1);
      op_chk("R7 denorm to normal", 32'h00400000, 32'h00400000, 1'b0, NE, 32'h00800000, 1'b0, 1'b0);
      op_chk("R7 normal to denorm", 32'h00800001, 32'h00800000, 1'b1, NE, 32'h00000001, 1'b0, 1'b1);
   endtask

   task automatic t_special;
      op_chk("R8 qnan in", 32'h7FC00000, 32'h3F800000, 1'b0, NE, 32'h7FC00000, 1'b0, 1'b0);
      op_chk("R8 snan in b", 32'h3F800000, 32'hFF800001, 1'b0, NE, 32'h7FC00000, 1'b0, 1'b0);
      op_chk("R8 inf+(-inf)", 32'h7F800000, 32'hFF800000, 1'b0, NE, 32'h7FC00000, 1'b0, 1'b0);
      op_chk("R8 inf-inf", 32'h7F800000, 32'h7F800000, 1'b1, NE, 32'h7FC00000, 1'b0, 1'b0);
      op_chk("R9 inf+1", 32'h7F800000, 32'h3F800000, 1'b0, NE, 32'h7F800000, 1'b0, 1'b0);
      op_chk("R9 1-inf", 32'h3F800000, 32'h7F800000, 1'b1, NE, 32'hFF800000, 1'b0, 1'b0);
      op_chk("R9 inf+inf", 32'h7F800000, 32'h7F800000, 1'b0, NE, 32'h7F800000, 1'b0, 1'b0);
   endtask

   task automatic t_zero;
      op_chk("R10 1-1 nearest", 32'h3F800000, 32'h3F800000, 1'b1, NE, 32'h00000000, 1'b0, 1'b0);
      op_chk("R10 1-1 down", 32'h3F800000, 32'h3F800000, 1'b1, DN, 32'h80000000, 1'b0, 1'b0);
      op_chk("R10 -0+-0", 32'h80000000, 32'h80000000, 1'b0, NE, 32'h80000000, 1'b0, 1'b0);
      op_chk("R10 +0+-0 nearest", 32'h00000000, 32'h80000000, 1'b0, NE, 32'h00000000, 1'b0, 1'b0);
      op_chk("R10 +0+-0 down", 32'h00000000, 32'h80000000, 1'b0, DN, 32'h80000000, 1'b0, 1'b0);
   endtask

   task automatic t_timing;
      logic [31:0] held;
      run_op(32'h3F800000, 32'h40000000, 1'b0, NE);
      chk("R11 latency", lat, 4);
      held = result_o;
      repeat (3) @(negedge clk);
      chk("R11 done single cycle", {31'd0, done_o}, 32'd0);
      chk("R11 result held", result_o, held);
   endtask

   task automatic t_busy;
      int extra;
      @(negedge clk);
      op_a_i = 32'h3F800000; op_b_i = 32'h40000000; sub_i = 1'b0; rmode_i = NE; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      op_a_i = 32'h40400000; op_b_i = 32'h40400000;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      for (int i = 2; i <= 10; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (done_o) begin lat = i; break; end
      end
      chk("R12 first op result kept", result_o, 32'h40400000);
      chk("R12 latency from first start", lat, 4);
      extra = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (done_o) extra++;
      end
      chk("R12 no second completion", extra, 0);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_add_sub();
      t_round();
      t_overflow();
      t_denorm();
      t_special();
      t_zero();
      t_timing();
      t_busy();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule